// File: doc/BRIEF.md
# Gaussian Transmit Pulse Shaper

This block turns a serial transmit bit stream into a sequence of signed frequency-control samples for an FM modulator. It runs on the filter clock, which is six times the bit rate (6.912 MHz against 1.152 Mbit/s). Each accepted bit is mapped to a polarity (+1 for a one, -1 for a zero) and repeated for six consecutive samples. The oversampled polarity stream passes through a six-tap symmetric FIR with a Gaussian impulse response (BT = 0.5). Each filtered value is then multiplied by a deviation factor selected by a 3-bit code, giving 60 % to 130 % of nominal deviation in 10 % steps.

The coefficients are 10, 22, 32, 32, 22, 10. They sum to 128, so a long run of equal bits settles at exactly plus or minus 128 times the deviation factor (6 + code). At 100 % (code 100) the full-scale output is 1280 LSB, which stands for the nominal peak deviation of 400 kHz. Both edges of the block are valid/ready streams. The shaper takes one bit at the start of every six-sample period. If no bit is offered at that moment it stalls, and it produces no samples until a bit arrives. A single output register carries each sample. When the consumer holds off, that register holds its sample and the whole filter freezes. An enable input switches the block off. While the enable is low the output reads zero deviation and nothing is accepted.

Top module: `gauss_tx_shaper`

## Requirements
- R1: While `en` is low (and after reset), `out_valid` is 0, `out_sample` is 0 and `in_ready` is 0.
- R2: At most one bit is accepted per six output samples. `in_ready` is high only when enabled, at the start of a bit period, and while the output register is empty or being drained. It is never high in the cycle right after an accepted bit.
- R3: Input bit value 1 enters the filter as +1 and value 0 as -1. Each accepted bit occupies six successive filter samples, and the first of them is produced in the cycle the bit is accepted.
- R4: Each output sample equals (sum over the six newest polarity samples of coefficient times polarity) times (6 + `dev_code`), with coefficients 10, 22, 32, 32, 22, 10.
- R5: Six or more consecutive samples of the same polarity give exactly +128·(6 + `dev_code`) for ones, or the negative of it for zeros.
- R6: The deviation code k (binary 000 to 111) scales the full-scale output to (60 + 10·k) % of 1280 LSB. Code 000 gives 768 and code 111 gives 1664.
- R7: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with the same `out_sample`, and `in_ready` stays low.
- R8: If no bit is offered at a bit boundary, no sample is produced and no state changes. When a bit arrives later, the sample sequence continues as if there had been no gap.
- R9: When the block is enabled, the delay line is preset to alternating polarity with the newest position at +1. That preset has a weighted sum of zero.
- R10: The magnitude of `out_sample` never exceeds 1664.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock (6x bit rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Shaper enable; low forces zero deviation and clears state |
| dev_code | input | 3 | Deviation scale code, factor 6 + code (tenths) |
| in_valid | input | 1 | A transmit bit is offered |
| in_ready | output | 1 | The bit is taken at this edge |
| in_bit | input | 1 | Transmit bit value |
| out_valid | output | 1 | `out_sample` holds an unconsumed sample |
| out_ready | input | 1 | Consumer takes the sample at this edge |
| out_sample | output | 12 | Signed frequency-control sample |

## Verification
The assertions assume that `dev_code` only changes while the block is disabled. They also assume that `in_bit` is stable whenever `in_valid` is high, because the filter clock samples it directly with no extra capture stage. The stimulus follows both rules. It changes the code only between runs, with `en` low. It drives the bit, the valid and the ready signals half a period away from the sampling edge, which gives wide setup and hold margins. Within these rules, the valid and ready patterns stall both edges in irregular ways. This checks that back-pressure and input starvation never lose, repeat or reorder samples.

// File: rtl/gts_pkg.sv
`timescale 1ns/1ps
package gts_pkg;
  localparam int OSR        = 6;
  localparam int NTAP       = 6;
  localparam int COEF_W     = 8;
  localparam int ACC_W      = 10;
  localparam int OUT_W      = 12;
  localparam int CODE_W     = 3;
  localparam int SCALE_BASE = 6;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Gaussian BT=0.5 pulse sampled at six points, sum normalised to 128
  function automatic coef_t tap_coef(input int idx);
    case (idx)
      0, 5:    return coef_t'(10);
      1, 4:    return coef_t'(22);
      default: return coef_t'(32);
    endcase
  endfunction

  function automatic int coef_sum(input int ntap);
    int s;
    s = 0;
    for (int i = 0; i < ntap; i++) s += int'(tap_coef(i));
    return s;
  endfunction
endpackage

// File: rtl/gts_pacer.sv
`timescale 1ns/1ps
module gts_pacer #(
  parameter int OSR = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic in_valid,
  input  logic in_bit,
  input  logic slot_free,
  output logic in_ready,
  output logic advance,
  output logic cur_sample
);
  localparam int PH_W = (OSR > 1) ? $clog2(OSR) : 1;

  logic [PH_W-1:0] phase;
  logic            held_bit;
  logic            at_bound;

  assign at_bound   = (phase == '0);
  assign in_ready   = en && at_bound && slot_free;
  assign advance    = en && slot_free && (!at_bound || in_valid);
  assign cur_sample = at_bound ? in_bit : held_bit;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      phase    <= '0;
      held_bit <= 1'b0;
    end else if (advance) begin
      held_bit <= cur_sample;
      phase    <= (phase == PH_W'(OSR-1)) ? '0 : phase + 1'b1;
    end
  end

  AST_ONE_BIT_PER_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R2

  AST_STARVED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_bound && !in_valid) |-> !advance); // R8
endmodule

// File: rtl/gts_fir.sv
`timescale 1ns/1ps
module gts_fir
  import gts_pkg::*;
#(
  parameter int NTAP  = 6,
  parameter int ACC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    advance,
  input  logic                    cur_sample,
  output logic signed [ACC_W-1:0] acc_next
);
  function automatic logic [NTAP-1:0] alt_init();
    logic [NTAP-1:0] v;
    for (int i = 0; i < NTAP; i++) v[i] = (i % 2 == 0);
    return v;
  endfunction

  localparam logic [NTAP-1:0] LINE_INIT = alt_init();

  logic [NTAP-1:0]         line_q;
  logic [NTAP-1:0]         line_d;
  logic signed [ACC_W-1:0] term [NTAP];

  assign line_d = {line_q[NTAP-2:0], cur_sample};

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    localparam logic signed [ACC_W-1:0] CW = ACC_W'(tap_coef(i));
    assign term[i] = line_d[i] ? CW : -CW;
  end

  always_comb begin
    acc_next = '0;
    for (int i = 0; i < NTAP; i++) acc_next = acc_next + term[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) line_q <= LINE_INIT;
    else if (advance)  line_q <= line_d;
  end

  AST_LINE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !advance) |=> (en ? $stable(line_q) : 1'b1)); // R8
endmodule

// File: rtl/gts_scale.sv
`timescale 1ns/1ps
module gts_scale #(
  parameter int ACC_W      = 10,
  parameter int OUT_W      = 12,
  parameter int CODE_W     = 3,
  parameter int SCALE_BASE = 6
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic [CODE_W-1:0]       code,
  output logic signed [OUT_W-1:0] sample
);
  logic signed [OUT_W-1:0] acc_ext;
  logic signed [OUT_W-1:0] fact;

  assign acc_ext = OUT_W'(acc);
  assign fact    = OUT_W'(SCALE_BASE) + OUT_W'(code);
  assign sample  = acc_ext * fact;
endmodule

// File: rtl/gauss_tx_shaper.sv
`timescale 1ns/1ps
module gauss_tx_shaper
  import gts_pkg::*;
#(
  parameter int P_OSR    = OSR,
  parameter int P_NTAP   = NTAP,
  parameter int P_ACC_W  = ACC_W,
  parameter int P_OUT_W  = OUT_W,
  parameter int P_CODE_W = CODE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [P_CODE_W-1:0]       dev_code,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic                      in_bit,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic signed [P_OUT_W-1:0] out_sample
);
  localparam int FULL_SUM = coef_sum(P_NTAP);
  localparam int MAX_MAG  = FULL_SUM * (SCALE_BASE + (1 << P_CODE_W) - 1);

  logic                      slot_free;
  logic                      advance;
  logic                      cur_sample;
  logic signed [P_ACC_W-1:0] acc_next;
  logic signed [P_OUT_W-1:0] scaled;

  assign slot_free = !out_valid || out_ready;

  gts_pacer #(.OSR(P_OSR)) u_pacer (
    .clk(clk), .rst_n(rst_n), .en(en),
    .in_valid(in_valid), .in_bit(in_bit), .slot_free(slot_free),
    .in_ready(in_ready), .advance(advance), .cur_sample(cur_sample)
  );

  gts_fir #(.NTAP(P_NTAP), .ACC_W(P_ACC_W)) u_fir (
    .clk(clk), .rst_n(rst_n), .en(en),
    .advance(advance), .cur_sample(cur_sample), .acc_next(acc_next)
  );

  gts_scale #(.ACC_W(P_ACC_W), .OUT_W(P_OUT_W), .CODE_W(P_CODE_W),
              .SCALE_BASE(SCALE_BASE)) u_scale (
    .acc(acc_next), .code(dev_code), .sample(scaled)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (advance) begin
      out_valid  <= 1'b1;
      out_sample <= scaled;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && out_sample == '0)); // R1

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (en && out_valid && !out_ready) |=> (!en || (out_valid && $stable(out_sample)))); // R7

  AST_NO_TAKE_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sample <= P_OUT_W'(MAX_MAG) && out_sample >= -P_OUT_W'(MAX_MAG))); // R10
endmodule

// File: tb/sim_gauss_tx_shaper.sv
`timescale 1ns/1ps
module sim_gauss_tx_shaper;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = CLK_PERIOD / 2;
  localparam int NBITS      = 384;
  localparam int WATCHDOG   = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              en = 1'b0;
  logic [2:0]        dev_code = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_bit = 1'b0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic signed [11:0] out_sample;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  int exp_q[$];
  string tag_q[$];
  int hist[6];
  int k_cur;
  int pushed_since_en;
  logic [15:0] lfsr = 16'hACE1;

  always #(HALF) clk = ~clk;

  gauss_tx_shaper u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dev_code(dev_code),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_sample(out_sample)
  );

  function automatic int coef(input int i);
    if (i == 0 || i == 5) return 10;
    if (i == 1 || i == 4) return 22;
    return 32;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // R9: preset alternating polarity, newest at +1
  task automatic model_reset();
    for (int i = 0; i < 6; i++) hist[i] = (i % 2 == 0) ? 1 : -1;
    pushed_since_en = 0;
  endtask

  // R3: one bit -> six samples of its polarity; R4 weighted sum times (6+k)
  task automatic model_push(input bit b);
    for (int s = 0; s < 6; s++) begin
      int acc;
      bit all_pos;
      for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = b ? 1 : -1;
      acc = 0;
      all_pos = 1;
      for (int i = 0; i < 6; i++) begin
        acc += coef(i) * hist[i];
        if (hist[i] != 1) all_pos = 0;
      end
      exp_q.push_back(acc * (6 + k_cur));
      if (pushed_since_en < 6) tag_q.push_back("R9");
      else if (all_pos) tag_q.push_back("R5");
      else tag_q.push_back("R4");
      pushed_since_en++;
    end
  endtask

  task automatic check_off(input string req);
    check(out_valid == 1'b0, req, int'(out_valid), 0);
    check(out_sample == 0, req, int'(out_sample), 0);
    check(in_ready == 1'b0, req, int'(in_ready), 0);
  endtask

  task automatic run_code(input int k);
    int bi;
    int guard;
    bit prev_stall;
    int stall_val;
    @(negedge clk);
    en = 1'b0;
    in_valid = 1'b0;
    dev_code = 3'(k);
    k_cur = k;
    repeat (2) @(negedge clk);
    #1 check_off("R1");
    model_reset();
    exp_q.delete();
    tag_q.delete();
    en = 1'b1;
    bi = 0;
    guard = 0;
    prev_stall = 0;
    stall_val = 0;
    while ((bi < NBITS || exp_q.size() > 0) && guard < 20000 && !finished) begin
      @(negedge clk);
      guard++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_valid  = (bi < NBITS) && (lfsr[1:0] != 2'b00);
      in_bit    = ((bi / 6) >> (5 - (bi % 6))) & 1;
      out_ready = (bi >= NBITS) || (lfsr[4:3] != 2'b00);
      #(HALF - 1);
      if (prev_stall) begin
        // R7: held sample must not move
        check(out_valid == 1'b1, "R7", int'(out_valid), 1);
        check(int'(out_sample) == stall_val, "R7", int'(out_sample), stall_val);
      end
      prev_stall = 0;
      if (out_valid && !out_ready) begin
        prev_stall = 1;
        stall_val = int'(out_sample);
        check(in_ready == 1'b0, "R7", int'(in_ready), 0);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R2", int'(out_sample), 0);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          // R3 R8: sequence continuity across gaps
          check(int'(out_sample) == e, t, int'(out_sample), e);
          if (t == "R5")
            check(int'(out_sample) == (1280 * (60 + 10 * k)) / 100, "R6",
                  int'(out_sample), (1280 * (60 + 10 * k)) / 100);
          check(out_sample <= 1664 && out_sample >= -1664, "R10", int'(out_sample), 1664);
        end
      end
      if (in_valid && in_ready) begin
        model_push(in_bit);
        bi++;
      end
    end
    check(exp_q.size() == 0 && bi == NBITS, "R2", exp_q.size(), 0);
    // R8: starved at bit boundary -> nothing more appears
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (8) @(negedge clk);
    #1 check(out_valid == 1'b0, "R8", int'(out_valid), 0);
    en = 1'b0;
    @(negedge clk);
    #1 check_off("R1");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check_off("R1");
    rst_n = 1'b1;
    @(negedge clk);
    #1 check_off("R1");
    for (int k = 0; k < 8; k++) run_code(k);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule